// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the receive half of a descriptor-ring DMA controller. A frame is offered on a valid/ready port as a length and three class flags (broadcast, multicast, own-address match). The engine fetches the current 16-byte descriptor from a 64-bit ring base plus sixteen times the ring index. It checks that the device owns the descriptor and that the buffer is large enough. It then issues one bulk frame-data write to the buffer address held in the descriptor and appends a zero 32-bit checksum word. Finally it writes the updated status back into the first two descriptor words and moves the ring index on.

A frame that cannot be placed is dropped without touching memory or the index, and is reported as an overflow event together with a missed-frame strobe. A placed frame produces an rx-ok event and one per-class counter strobe for each class flag that was set. Only one frame is in flight at a time. `frm_ready` is high only while the engine is idle. It drops for the whole fetch, check and writeback sequence, and the source must hold its fields stable while `frm_valid` waits. The memory command port is also valid/ready: once raised, a command holds its op, address, data and length unchanged until `mem_cmd_ready` takes it. Each read gets exactly one `mem_rd_valid` response, which may come any number of cycles later.

Top module: `rx_desc_wb`

## Requirements
- R1: A frame is taken only on a cycle with `frm_valid` and `frm_ready` both high; `frm_ready` is high only when idle and is low in the cycle after a frame is taken, until that frame's drop or final writeback completes.
- R2: For each frame the engine issues four word reads (op 0) at descriptor address base + 16*index, in the order +0, +4, +8, +12. Words 2 and 3 are the low and high halves of the 64-bit buffer address.
- R3: If bit 31 (device owns) of word 0 is clear, the frame is dropped: `evt_overflow` and `cnt_miss_stb` pulse for one cycle, no write command is issued and the index is unchanged.
- R4: If padded length + 4 exceeds word 0 bits 12:0 (buffer size), the frame is dropped exactly as in R3; a size equal to padded length + 4 is accepted.
- R5: A frame shorter than MIN_LEN (default 60) bytes is treated as MIN_LEN bytes long for the capacity check, the data write and the size written back.
- R6: An accepted frame first gets one frame write (op 2) at the buffer address with `mem_cmd_len` equal to the padded length, then a word write (op 1) of value zero at buffer address + padded length.
- R7: Word 0 is written back with bit 31 cleared, bits 29 and 28 set, bit 26 ORed with multicast, bit 25 with address match, bit 24 with broadcast, bits 12:0 replaced by padded length + 4, and all other bits kept.
- R8: After the word-0 write (op 1 at descriptor +0), word 1 is written (op 1 at descriptor +4) with bit 16 cleared and all other bits kept; words 2 and 3 are never written.
- R9: After the word-1 write, the index becomes 0 if word 0 bit 30 (end of ring) was set, and otherwise increments by one.
- R10: `evt_rx_ok` pulses for one cycle after the word-1 write. In that same cycle, `cnt_class_stb` bit 0 (broadcast), bit 1 (multicast) and bit 2 (address match) echo the frame's flags. `evt_rx_ok` and `evt_overflow` never pulse together.
- R11: After reset the index is 0, `frm_ready` is high, and no command or event is raised.
- R12: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command stays raised with op, address, data and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 64 | Byte address of descriptor 0 |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Engine idle, frame may be taken |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_bcast | input | 1 | Frame is broadcast |
| frm_mcast | input | 1 | Frame is multicast |
| frm_phys | input | 1 | Frame matched the station address |
| mem_cmd_valid | output | 1 | Memory command raised |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_op | output | 2 | 0 word read, 1 word write, 2 frame write |
| mem_cmd_addr | output | 64 | Byte address |
| mem_cmd_wdata | output | 32 | Word write data |
| mem_cmd_len | output | LEN_W | Byte count of a frame write |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| evt_rx_ok | output | 1 | Frame placed, one-cycle pulse |
| evt_overflow | output | 1 | Frame dropped, one-cycle pulse |
| cnt_miss_stb | output | 1 | Missed-frame counter strobe |
| cnt_class_stb | output | 3 | Per-class counter strobes {match, multicast, broadcast} |

## Verification
Directed frames cover the edge cases: a runt frame separates padding from the raw length, and sizes one byte either side of the fit point separate `>` from `>=` in the capacity check. A cleared ownership bit separates the ownership drop from the capacity drop. Random frames mix lengths, class flags, ownership and buffer sizes near and far from the limit, and random junk in the preserved word-0 and word-1 bits shows which bits the writeback keeps or changes. The ring of four with end-of-ring on the last descriptor forces repeated wraps, so a dropped frame that wrongly advanced the index shows up as a wrong read address on the next frame. Random ready stalls and read latencies test that commands are held stable.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_FRAME = 2'd2
  } mem_op_e;

  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 30;
  localparam int FS_BIT  = 29;
  localparam int LS_BIT  = 28;
  localparam int MC_BIT  = 26;
  localparam int PM_BIT  = 25;
  localparam int BC_BIT  = 24;
  localparam int TAG_BIT = 16;
  localparam int SIZE_W  = 13;

  typedef struct packed {
    logic phys;
    logic mcast;
    logic bcast;
  } cls_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_EVAL,
    S_W_FRAME,
    S_W_CSUM,
    S_W_D0,
    S_W_D1
  } st_e;
endpackage

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
  parameter int IDX_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] base,
  input  logic        advance,
  input  logic        wrap,
  output logic [63:0] desc_addr
);
  localparam int PAD_W = 64 - IDX_W - 4;

  logic [IDX_W-1:0] idx_q;

  assign desc_addr = base + {{PAD_W{1'b0}}, idx_q, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= wrap ? '0 : idx_q + 1'b1;
  end

  // R9: end-of-ring returns to descriptor zero
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    advance && wrap |=> desc_addr == base);
  // R3: index holds unless a writeback completes
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(idx_q));
endmodule

// File: rtl/rxwb_desc_eval.sv
module rxwb_desc_eval
  import rxwb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [31:0]      w0,
  input  logic [31:0]      w1,
  input  logic [LEN_W-1:0] plen,
  input  cls_t             cls,
  output logic             own_ok,
  output logic             fits,
  output logic             eor,
  output logic [31:0]      new_w0,
  output logic [31:0]      new_w1
);
  localparam int SUM_W = (LEN_W + 1 > SIZE_W) ? LEN_W + 1 : SIZE_W;

  logic [SUM_W-1:0] need;
  logic [SUM_W-1:0] room;

  assign need   = SUM_W'(plen) + SUM_W'(4);
  assign room   = SUM_W'(w0[SIZE_W-1:0]);
  assign own_ok = w0[OWN_BIT];
  assign fits   = need <= room;
  assign eor    = w0[EOR_BIT];

  always_comb begin
    new_w0 = w0;
    new_w0[OWN_BIT] = 1'b0;
    new_w0[FS_BIT]  = 1'b1;
    new_w0[LS_BIT]  = 1'b1;
    new_w0[MC_BIT]  = w0[MC_BIT] | cls.mcast;
    new_w0[PM_BIT]  = w0[PM_BIT] | cls.phys;
    new_w0[BC_BIT]  = w0[BC_BIT] | cls.bcast;
    new_w0[SIZE_W-1:0] = need[SIZE_W-1:0];
    new_w1 = w1;
    new_w1[TAG_BIT] = 1'b0;
  end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
  import rxwb_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      ring_base,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_bcast,
  input  logic             frm_mcast,
  input  logic             frm_phys,
  output logic             mem_cmd_valid,
  input  logic             mem_cmd_ready,
  output logic [1:0]       mem_cmd_op,
  output logic [63:0]      mem_cmd_addr,
  output logic [31:0]      mem_cmd_wdata,
  output logic [LEN_W-1:0] mem_cmd_len,
  input  logic             mem_rd_valid,
  input  logic [31:0]      mem_rd_data,
  output logic             evt_rx_ok,
  output logic             evt_overflow,
  output logic             cnt_miss_stb,
  output logic [2:0]       cnt_class_stb
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  st_e              st_q;
  logic [1:0]       rd_sel_q;
  logic [31:0]      dw_q [4];
  logic [LEN_W-1:0] plen_q;
  cls_t             cls_q;

  logic [LEN_W-1:0] plen_in;
  logic [63:0]      desc_addr;
  logic [63:0]      buf_addr;
  logic             own_ok, fits, eor;
  logic [31:0]      new_w0, new_w1;
  logic             advance;
  mem_op_e          op;

  assign plen_in   = (frm_len < MIN_L) ? MIN_L : frm_len;
  assign frm_ready = (st_q == S_IDLE);
  assign buf_addr  = {dw_q[3], dw_q[2]};
  assign advance   = (st_q == S_W_D1) && mem_cmd_ready;
  assign mem_cmd_op = op;

  rxwb_ring_ptr #(.IDX_W(IDX_W)) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (ring_base),
    .advance   (advance),
    .wrap      (eor),
    .desc_addr (desc_addr)
  );

  rxwb_desc_eval #(.LEN_W(LEN_W)) eval_i (
    .w0     (dw_q[0]),
    .w1     (dw_q[1]),
    .plen   (plen_q),
    .cls    (cls_q),
    .own_ok (own_ok),
    .fits   (fits),
    .eor    (eor),
    .new_w0 (new_w0),
    .new_w1 (new_w1)
  );

  always_comb begin
    mem_cmd_valid = 1'b0;
    op            = OP_RD;
    mem_cmd_addr  = '0;
    mem_cmd_wdata = '0;
    mem_cmd_len   = '0;
    unique case (st_q)
      S_RD_REQ: begin
        mem_cmd_valid = 1'b1;
        op            = OP_RD;
        mem_cmd_addr  = desc_addr + {60'd0, rd_sel_q, 2'b00};
      end
      S_W_FRAME: begin
        mem_cmd_valid = 1'b1;
        op            = OP_FRAME;
        mem_cmd_addr  = buf_addr;
        mem_cmd_len   = plen_q;
      end
      S_W_CSUM: begin
        mem_cmd_valid = 1'b1;
        op            = OP_WR;
        mem_cmd_addr  = buf_addr + 64'(plen_q);
        mem_cmd_wdata = 32'd0;
      end
      S_W_D0: begin
        mem_cmd_valid = 1'b1;
        op            = OP_WR;
        mem_cmd_addr  = desc_addr;
        mem_cmd_wdata = new_w0;
      end
      S_W_D1: begin
        mem_cmd_valid = 1'b1;
        op            = OP_WR;
        mem_cmd_addr  = desc_addr + 64'd4;
        mem_cmd_wdata = new_w1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      rd_sel_q      <= '0;
      for (int i = 0; i < 4; i++) dw_q[i] <= '0;
      plen_q        <= '0;
      cls_q         <= '0;
      evt_rx_ok     <= 1'b0;
      evt_overflow  <= 1'b0;
      cnt_miss_stb  <= 1'b0;
      cnt_class_stb <= '0;
    end else begin
      evt_rx_ok     <= 1'b0;
      evt_overflow  <= 1'b0;
      cnt_miss_stb  <= 1'b0;
      cnt_class_stb <= '0;
      unique case (st_q)
        S_IDLE: if (frm_valid) begin
          plen_q   <= plen_in;
          cls_q    <= '{phys: frm_phys, mcast: frm_mcast, bcast: frm_bcast};
          rd_sel_q <= '0;
          st_q     <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_cmd_ready) st_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rd_valid) begin
          dw_q[rd_sel_q] <= mem_rd_data;
          rd_sel_q       <= rd_sel_q + 2'd1;
          st_q           <= (rd_sel_q == 2'd3) ? S_EVAL : S_RD_REQ;
        end
        S_EVAL: begin
          if (own_ok && fits) begin
            st_q <= S_W_FRAME;
          end else begin
            evt_overflow <= 1'b1;
            cnt_miss_stb <= 1'b1;
            st_q         <= S_IDLE;
          end
        end
        S_W_FRAME: if (mem_cmd_ready) st_q <= S_W_CSUM;
        S_W_CSUM:  if (mem_cmd_ready) st_q <= S_W_D0;
        S_W_D0:    if (mem_cmd_ready) st_q <= S_W_D1;
        S_W_D1: if (mem_cmd_ready) begin
          evt_rx_ok     <= 1'b1;
          cnt_class_stb <= {cls_q.phys, cls_q.mcast, cls_q.bcast};
          st_q          <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R12: a stalled command is held unchanged
  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_op)
      && $stable(mem_cmd_addr) && $stable(mem_cmd_wdata) && $stable(mem_cmd_len));
  // R1: no new frame while one is in flight
  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready |=> !frm_ready);
  // R10: success and drop are exclusive
  a_r10_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rx_ok, evt_overflow}));
  // R10: class strobes only with a success event
  a_r10_class_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_class_stb != 3'b000) |-> evt_rx_ok);
  // R3: data written only into an owned descriptor
  a_r3_frame_owned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && (mem_cmd_op == 2'd2) |-> dw_q[0][OWN_BIT]);
  // R4: data written only when it fits
  a_r4_frame_fits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && (mem_cmd_op == 2'd2)
      |-> (32'(mem_cmd_len) + 32'd4) <= 32'(dw_q[0][SIZE_W-1:0]));
  // R3: a drop is flagged together with the miss strobe
  a_r3_miss_with_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |-> cnt_miss_stb && !mem_cmd_valid);
endmodule

// File: tb/rx_desc_wb_tb_top.sv
`timescale 1ns/1ps
module rx_desc_wb_tb_top;
  localparam int LEN_W = 16;
  localparam int MINL  = 60;
  localparam logic [63:0] BASE = 64'h0000_0005_8000_0100;
  localparam logic [31:0] JUNK = 32'h08FF_E000;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic             frm_valid = 0, frm_ready;
  logic [LEN_W-1:0] frm_len = 0;
  logic             frm_bcast = 0, frm_mcast = 0, frm_phys = 0;
  logic             mem_cmd_valid, mem_cmd_ready = 0;
  logic [1:0]       mem_cmd_op;
  logic [63:0]      mem_cmd_addr;
  logic [31:0]      mem_cmd_wdata;
  logic [LEN_W-1:0] mem_cmd_len;
  logic             mem_rd_valid = 0;
  logic [31:0]      mem_rd_data = 0;
  logic             evt_rx_ok, evt_overflow, cnt_miss_stb;
  logic [2:0]       cnt_class_stb;

  rx_desc_wb dut_i (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_len(frm_len),
    .frm_bcast(frm_bcast), .frm_mcast(frm_mcast), .frm_phys(frm_phys),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_op(mem_cmd_op), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata), .mem_cmd_len(mem_cmd_len),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .evt_rx_ok(evt_rx_ok), .evt_overflow(evt_overflow),
    .cnt_miss_stb(cnt_miss_stb), .cnt_class_stb(cnt_class_stb)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: four descriptors
  logic [31:0] mem [4][4];
  int          n_log = 0;
  logic [1:0]  log_op [8];
  logic [63:0] log_addr [8];
  logic [31:0] log_data [8];
  logic [15:0] log_len [8];
  bit          rd_pend = 0;
  int          rd_dly = 0;
  logic [31:0] rd_word = 0;
  bit          stall_prev = 0;
  logic [1:0]  s_op;
  logic [63:0] s_addr;
  logic [31:0] s_data;
  logic [15:0] s_len;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rdy;
      mem_rd_valid = 0;
      if (rd_pend) begin
        if (rd_dly == 0) begin
          mem_rd_valid = 1; mem_rd_data = rd_word; rd_pend = 0;
        end else rd_dly--;
      end
      if (stall_prev)  // R12
        chk(mem_cmd_valid && mem_cmd_op == s_op && mem_cmd_addr == s_addr &&
            mem_cmd_wdata == s_data && mem_cmd_len == s_len, "R12 stalled cmd held",
            mem_cmd_addr, s_addr);
      rdy = ($urandom % 4) != 0;
      mem_cmd_ready = rdy;
      stall_prev = mem_cmd_valid && !rdy;
      s_op = mem_cmd_op; s_addr = mem_cmd_addr; s_data = mem_cmd_wdata; s_len = mem_cmd_len;
      if (mem_cmd_valid && rdy) begin
        if (n_log < 8) begin
          log_op[n_log] = mem_cmd_op; log_addr[n_log] = mem_cmd_addr;
          log_data[n_log] = mem_cmd_wdata; log_len[n_log] = mem_cmd_len;
        end
        n_log++;
        if (mem_cmd_addr >= BASE && mem_cmd_addr < BASE + 64) begin
          int di, wi;
          di = int'((mem_cmd_addr - BASE) >> 4);
          wi = int'((mem_cmd_addr >> 2) & 64'd3);
          if (mem_cmd_op == 2'd0) begin
            rd_word = mem[di][wi]; rd_pend = 1; rd_dly = $urandom % 3;
          end else if (mem_cmd_op == 2'd1) mem[di][wi] = mem_cmd_wdata;
        end else if (mem_cmd_op == 2'd0) begin
          rd_word = 32'hDEAD_BEEF; rd_pend = 1; rd_dly = 0;
        end
      end
    end
  end

  function automatic logic [31:0] exp_w0(input logic [31:0] w, input int plen, input logic [2:0] c);
    logic [31:0] r = w;
    r[31] = 0; r[29] = 1; r[28] = 1;
    r[26] = r[26] | c[1]; r[25] = r[25] | c[2]; r[24] = r[24] | c[0];
    r[12:0] = 13'(plen + 4);
    return r;
  endfunction

  int exp_idx = 0;

  // c: bit0 bcast, bit1 mcast, bit2 phys
  task automatic run_frame(input int len, input logic [2:0] c, input bit own, input int size);
    logic [31:0] w0, w1, w2, w3;
    logic [63:0] da, ba;
    int plen, t;
    bit exp_ok, got_ok, got_ovf;
    logic [2:0] got_cls;
    bit got_miss;
    w0 = ($urandom & JUNK) | (32'(own) << 31) | (32'(exp_idx == 3) << 30) | 32'(size & 13'h1FFF);
    w1 = $urandom; w2 = $urandom; w3 = $urandom;
    mem[exp_idx][0] = w0; mem[exp_idx][1] = w1; mem[exp_idx][2] = w2; mem[exp_idx][3] = w3;
    da = BASE + 64'(exp_idx * 16);
    ba = {w3, w2};
    plen = (len < MINL) ? MINL : len;
    exp_ok = own && (plen + 4 <= size);
    @(negedge clk);
    n_log = 0;
    frm_valid = 1; frm_len = 16'(len);
    frm_bcast = c[0]; frm_mcast = c[1]; frm_phys = c[2];
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 0;
    chk(!frm_ready, "R1 ready low after take", 64'(frm_ready), 0);
    t = 0; got_ok = 0; got_ovf = 0;
    while (!(evt_rx_ok || evt_overflow) && t < 300) begin @(negedge clk); t++; end
    got_ok = evt_rx_ok; got_ovf = evt_overflow; got_cls = cnt_class_stb; got_miss = cnt_miss_stb;
    chk(t < 300, "R1 frame completes", 64'(t), 0);
    chk(got_ok == exp_ok && got_ovf == !exp_ok, exp_ok ? "R4 accept outcome" : "R3 R4 drop outcome",
        64'({got_ok, got_ovf}), 64'({exp_ok, !exp_ok}));
    for (int k = 0; k < 4; k++)
      chk(n_log > k && log_op[k] == 2'd0 && log_addr[k] == da + 64'(4 * k),
          "R2 descriptor read", log_addr[k], da + 64'(4 * k));
    if (exp_ok) begin
      chk(n_log == 8, "R8 command count", 64'(n_log), 8);
      chk(log_op[4] == 2'd2 && log_addr[4] == ba, "R6 frame write addr", log_addr[4], ba);
      chk(log_len[4] == 16'(plen), "R5 padded frame length", 64'(log_len[4]), 64'(plen));
      chk(log_op[5] == 2'd1 && log_addr[5] == ba + 64'(plen) && log_data[5] == 0,
          "R6 checksum word", log_addr[5], ba + 64'(plen));
      chk(log_op[6] == 2'd1 && log_addr[6] == da && log_data[6] == exp_w0(w0, plen, c),
          "R7 word0 writeback", 64'(log_data[6]), 64'(exp_w0(w0, plen, c)));
      chk(log_op[7] == 2'd1 && log_addr[7] == da + 4 && log_data[7] == (w1 & ~32'h0001_0000),
          "R8 word1 writeback", 64'(log_data[7]), 64'(w1 & ~32'h0001_0000));
      chk(got_cls == c, "R10 class strobes", 64'(got_cls), 64'(c));
      chk(got_ovf == 0, "R10 no overflow on ok", 64'(got_ovf), 0);
      exp_idx = (w0[30]) ? 0 : exp_idx + 1;  // R9
    end else begin
      chk(n_log == 4, "R3 no write on drop", 64'(n_log), 4);
      chk(got_miss == 1, "R3 miss strobe", 64'(got_miss), 1);
      chk(mem[exp_idx][0] == w0, "R4 descriptor untouched", 64'(mem[exp_idx][0]), 64'(w0));
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) mem[i][j] = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(frm_ready == 1, "R11 ready after reset", 64'(frm_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(frm_ready == 1 && !mem_cmd_valid, "R11 idle after reset", 64'(mem_cmd_valid), 0);
    chk(!evt_rx_ok && !evt_overflow, "R11 no events after reset", 64'({evt_rx_ok, evt_overflow}), 0);
    // directed corners
    run_frame(10, 3'b001, 1, 200);   // R5 runt padded
    run_frame(200, 3'b010, 1, 204);  // R4 exact fit
    run_frame(200, 3'b100, 1, 203);  // R4 one short
    run_frame(100, 3'b001, 0, 4000); // R3 not owned
    run_frame(40, 3'b000, 1, 63);    // R5 padded fails capacity
    run_frame(40, 3'b000, 1, 64);    // R5 padded fits exactly
    for (int n = 0; n < 60; n++) begin : rnd
      int len, size;
      logic [2:0] c;
      len = 1 + ($urandom % 1600);
      c = 3'(1 << ($urandom % 4));
      size = (len < MINL ? MINL : len) + 4 + int'($urandom % 16) - 6;
      if (($urandom % 4) == 0) size = $urandom % 8192;
      run_frame(len, c, ($urandom % 8) != 0, size);
    end
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule